// File: doc/BRIEF.md
# Gated Input Latch Buffer

This block captures a 16-bit digital input word and queues each captured word in an internal first-in first-out store. The store can be written and read in the same clock cycle. There are two capture modes. In edge mode the word is taken at the rising edge of a strobe input. In window mode every bit that goes high at any time while a gate is open is collected, and the collected word is emitted when the gate closes. The gate can come from an input pin. It can also come from an internal gate generator, which opens a window of programmable length whenever the strobe rises.

Captured words can be written to the store at once. They can also be held in a one-word staging register until a second-level buffer command arrives. This lets a slower trigger decision choose which captures are kept. The consumer reads the store through a first-word-fall-through port. An interrupt line goes high when the number of stored words equals a programmed value. A write to a full store is dropped and sets a sticky overflow flag.

All inputs are synchronous to `clk`. The default store depth is 256 words. A 32K-word store is obtained with `DEPTH_LOG2 = 15`.

Top module: `gated_latch_buf`

## Requirements
- R1: After reset, `empty` = 1, `full` = 0, `count` = 0, `irq` = 0 and `overflow` = 0.
- R2: With `cfg_latch_mode` = 0, the word on `din` in the clock cycle where `strobe` is first sampled high after being low is captured. Holding `strobe` high captures nothing further.
- R3: With `cfg_latch_mode` = 1, the captured word is the bitwise OR of `din` over every cycle in which the selected gate is sampled high. It is emitted in the cycle the gate is first sampled low again.
- R4: Window mode starts each new gate window from an all-zero word, so bits from an earlier window never appear in a later one.
- R5: With `cfg_int_gate` = 1, the gate is produced internally and `gate_ext` is ignored. The internal gate is high for `cfg_gate_len` cycles, with a value of 0 treated as 1, starting the cycle after the strobe rises. A strobe rise while this gate is high is ignored.
- R6: With `cfg_auto_store` = 0, a captured word is held and enters the store only in a cycle where `buf_cmd` = 1. A newer capture replaces a held word that has not been written yet. A `buf_cmd` with no held word does nothing. With `cfg_auto_store` = 1, every capture enters the store.
- R7: `irq` is high exactly while `count` equals a nonzero `cfg_irq_level`.
- R8: A write while the store is full is dropped, the stored words are unchanged, and `overflow` goes high and stays high until reset.
- R9: The store is first-in first-out. `rd_data` shows the oldest word while `empty` = 0, and `rd_en` removes it. A read and a write may happen in the same cycle. `rd_en` while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | DATA_W | Data inputs |
| strobe | input | 1 | Capture strobe; its rising edge samples or starts the internal gate |
| gate_ext | input | 1 | External gate window |
| buf_cmd | input | 1 | Buffer command: write the held word to the store |
| cfg_latch_mode | input | 1 | 0 = edge capture, 1 = window capture |
| cfg_int_gate | input | 1 | 1 = use the internal gate generator |
| cfg_auto_store | input | 1 | 1 = store every capture, 0 = wait for `buf_cmd` |
| cfg_gate_len | input | GATE_W | Internal gate length in cycles (1 to 255) |
| cfg_irq_level | input | DEPTH_LOG2+1 | Word count that raises `irq` (0 disables) |
| rd_en | input | 1 | Remove the oldest stored word |
| rd_data | output | DATA_W | Oldest stored word |
| empty | output | 1 | Store holds no word |
| full | output | 1 | Store holds DEPTH words |
| count | output | DEPTH_LOG2+1 | Number of stored words |
| irq | output | 1 | Word-count interrupt |
| overflow | output | 1 | Sticky flag: a write was dropped |

## Verification
In edge mode, a strobe sampled high at clock edge k registers the capture at edge k. With automatic storage the word is in the store after edge k+1. In window mode the same two-edge path starts at the edge where the gate is first sampled low. With `buf_cmd` sampled at edge k, the word appears right after edge k. With the internal gate, a strobe sampled at edge e0 opens a window covering edges e1 to e0+len. The bench drives every input at the falling edge and lists each expected word in a queue as it drives it. A monitor compares the head of the store at each falling edge and pops it. Count, interrupt and flag checks wait at least two falling edges after the last stimulus, so both register stages have settled.

// File: rtl/glb_pkg.sv
package glb_pkg;

  // Effective internal gate length: zero is stretched to one cycle.
  function automatic int eff_gate_len(int len);
    return (len < 1) ? 1 : len;
  endfunction

  // Sticky accumulation of a window capture.
  function automatic logic [63:0] or_merge(logic [63:0] acc, logic [63:0] bits);
    return acc | bits;
  endfunction

  // Word-count interrupt condition.
  function automatic logic irq_hit(int cnt, int level);
    return (level != 0) && (cnt == level);
  endfunction

endpackage

// File: rtl/glb_gate_gen.sv
module glb_gate_gen #(
  parameter int GATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_rise,
  input  logic [GATE_W-1:0] cfg_gate_len,
  output logic              gen_gate
);
  import glb_pkg::*;

  logic [GATE_W-1:0] cnt;

  assign gen_gate = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - GATE_W'(1);
    end else if (strobe_rise) begin
      cnt <= GATE_W'(eff_gate_len(int'(cfg_gate_len)));
    end
  end

  AST_GATE_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt == $past(cnt) - GATE_W'(1))); // R5
  AST_GATE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_gate && strobe_rise) |=> gen_gate); // R5

endmodule

// File: rtl/glb_capture.sv
module glb_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              strobe,
  input  logic              gate_ext,
  input  logic              gen_gate,
  input  logic              cfg_latch_mode,
  input  logic              cfg_int_gate,
  output logic              strobe_rise,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_word
);
  import glb_pkg::*;

  logic              strobe_q;
  logic              gate_q;
  logic              gate_sel;
  logic              gate_open;
  logic              gate_close;
  logic [DATA_W-1:0] acc;

  assign strobe_rise = strobe & ~strobe_q;
  assign gate_sel    = cfg_int_gate ? gen_gate : gate_ext;
  assign gate_open   = gate_sel & ~gate_q;
  assign gate_close  = ~gate_sel & gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      gate_q    <= 1'b0;
      acc       <= '0;
      cap_word  <= '0;
      cap_valid <= 1'b0;
    end else begin
      strobe_q  <= strobe;
      gate_q    <= gate_sel;
      cap_valid <= 1'b0;
      if (cfg_latch_mode) begin
        if (gate_open) begin
          acc <= din;
        end else if (gate_sel) begin
          acc <= DATA_W'(or_merge(64'(acc), 64'(din)));
        end
        if (gate_close) begin
          cap_word  <= acc;
          cap_valid <= 1'b1;
        end
      end else if (strobe_rise) begin
        cap_word  <= din;
        cap_valid <= 1'b1;
      end
    end
  end

  AST_STROBE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_latch_mode && strobe && !strobe_q) |=> (cap_valid && cap_word == $past(din))); // R2
  AST_LATCH_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch_mode && $past(cfg_latch_mode) && cap_valid) |-> !gate_q); // R3

endmodule

// File: rtl/glb_stage.sv
module glb_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_word,
  input  logic              cfg_auto_store,
  input  logic              buf_cmd,
  output logic              push,
  output logic [DATA_W-1:0] push_word
);

  logic              pend_valid;
  logic [DATA_W-1:0] pend_word;

  assign push      = cfg_auto_store ? cap_valid : (buf_cmd & pend_valid);
  assign push_word = cfg_auto_store ? cap_word : pend_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_word  <= '0;
    end else if (cfg_auto_store) begin
      pend_valid <= 1'b0;
    end else if (cap_valid) begin
      pend_valid <= 1'b1;
      pend_word  <= cap_word;
    end else if (buf_cmd) begin
      pend_valid <= 1'b0;
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto_store && pend_valid && !cap_valid && !buf_cmd) |=> $stable(pend_word)); // R6

endmodule

// File: rtl/glb_fifo.sv
module glb_fifo #(
  parameter int DATA_W     = 16,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_word,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [DEPTH_LOG2:0] count,
  output logic              empty,
  output logic              full,
  output logic              overflow
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int CNT_W = DEPTH_LOG2 + 1;

  logic [DATA_W-1:0]     mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_ptr;
  logic [DEPTH_LOG2-1:0] rd_ptr;
  logic                  push_ok;
  logic                  pop_ok;
  logic                  push_drop;

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign push_ok   = push & ~full;
  assign push_drop = push & full;
  assign pop_ok    = rd_en & ~empty;
  assign rd_data   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + DEPTH_LOG2'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + DEPTH_LOG2'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (push_drop) overflow <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !rd_en) |=> (count == $past(count) && overflow)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !push) |=> empty); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R9

endmodule

// File: rtl/gated_latch_buf.sv
module gated_latch_buf #(
  parameter int DATA_W     = 16,
  parameter int GATE_W     = 8,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   din,
  input  logic                strobe,
  input  logic                gate_ext,
  input  logic                buf_cmd,
  input  logic                cfg_latch_mode,
  input  logic                cfg_int_gate,
  input  logic                cfg_auto_store,
  input  logic [GATE_W-1:0]   cfg_gate_len,
  input  logic [DEPTH_LOG2:0] cfg_irq_level,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  output logic                empty,
  output logic                full,
  output logic [DEPTH_LOG2:0] count,
  output logic                irq,
  output logic                overflow
);
  import glb_pkg::*;

  logic              strobe_rise;
  logic              gen_gate;
  logic              cap_valid;
  logic [DATA_W-1:0] cap_word;
  logic              push;
  logic [DATA_W-1:0] push_word;

  glb_gate_gen #(.GATE_W(GATE_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .strobe_rise(strobe_rise),
    .cfg_gate_len(cfg_gate_len), .gen_gate(gen_gate)
  );

  glb_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .din(din), .strobe(strobe),
    .gate_ext(gate_ext), .gen_gate(gen_gate),
    .cfg_latch_mode(cfg_latch_mode), .cfg_int_gate(cfg_int_gate),
    .strobe_rise(strobe_rise), .cap_valid(cap_valid), .cap_word(cap_word)
  );

  glb_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_word(cap_word),
    .cfg_auto_store(cfg_auto_store), .buf_cmd(buf_cmd),
    .push(push), .push_word(push_word)
  );

  glb_fifo #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word),
    .rd_en(rd_en), .rd_data(rd_data), .count(count), .empty(empty),
    .full(full), .overflow(overflow)
  );

  assign irq = irq_hit(int'(count), int'(cfg_irq_level));

  AST_HELD_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto_store && !buf_cmd) |=> (count <= $past(count))); // R6

endmodule

// File: tb/sim_gated_latch_buf.sv
`timescale 1ns/1ps
module sim_gated_latch_buf;
  localparam int DW = 16;
  localparam int DL = 4;
  localparam int DEPTH = 1 << DL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic strobe = 1'b0, gate_ext = 1'b0, buf_cmd = 1'b0;
  logic cfg_latch_mode = 1'b0, cfg_int_gate = 1'b0, cfg_auto_store = 1'b1;
  logic [7:0] cfg_gate_len = 8'd3;
  logic [DL:0] cfg_irq_level = '0;
  logic rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic empty, full, irq, overflow;
  logic [DL:0] count;

  int checks = 0;
  int errors = 0;
  logic mon_en = 1'b0;
  logic [DW-1:0] exp_q [$];

  always #2 clk = ~clk;

  gated_latch_buf #(.DATA_W(DW), .GATE_W(8), .DEPTH_LOG2(DL)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .strobe(strobe), .gate_ext(gate_ext),
    .buf_cmd(buf_cmd), .cfg_latch_mode(cfg_latch_mode), .cfg_int_gate(cfg_int_gate),
    .cfg_auto_store(cfg_auto_store), .cfg_gate_len(cfg_gate_len),
    .cfg_irq_level(cfg_irq_level), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .full(full), .count(count), .irq(irq), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Edge-mode capture: strobe high for one cycle, din then changes.
  task automatic strobe_word(input logic [DW-1:0] v, input bit expect_store);
    @(negedge clk); din = v; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0; din = ~v;
    if (expect_store) exp_q.push_back(v);
  endtask

  // Monitor: compares and pops the head of the store.
  always @(negedge clk) begin
    if (mon_en && !empty) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected word", int'(rd_data), -1);
      end else begin
        check("R9 order", int'(rd_data), int'(exp_q[0]));
        void'(exp_q.pop_front());
      end
      rd_en = 1'b1;
    end else begin
      rd_en = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 count", int'(count), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 overflow", int'(overflow), 0);
    rst_n = 1'b1;
    tick(2);

    // R2: edge capture, several patterns, through the store with reads
    mon_en = 1'b1;
    strobe_word(16'h1234, 1'b1);
    strobe_word(16'hFFFF, 1'b1);
    strobe_word(16'h0000, 1'b1);
    strobe_word(16'hA5C3, 1'b1);
    // R2: strobe held high, din changes: only the first word captured
    @(negedge clk); din = 16'h0F0F; strobe = 1'b1;
    exp_q.push_back(16'h0F0F);
    @(negedge clk); din = 16'hBEEF;
    @(negedge clk); din = 16'hCAFE;
    @(negedge clk); strobe = 1'b0; din = '0;
    tick(4);
    check("R2 all edge words consumed", exp_q.size(), 0);

    // R3: external gate window collects OR of bits; bit after close excluded
    cfg_latch_mode = 1'b1;
    @(negedge clk); gate_ext = 1'b1; din = 16'h0001;
    @(negedge clk); din = 16'h0100;
    @(negedge clk); din = 16'h0000;
    @(negedge clk); gate_ext = 1'b0; din = 16'h8000;
    exp_q.push_back(16'h0101);
    @(negedge clk); din = '0;
    tick(4);
    check("R3 window word consumed", exp_q.size(), 0);
    // R4: new window starts from zero
    @(negedge clk); gate_ext = 1'b1; din = 16'h0010;
    @(negedge clk); gate_ext = 1'b0; din = '0;
    exp_q.push_back(16'h0010);
    tick(4);
    check("R4 second window consumed", exp_q.size(), 0);

    // R5: internal gate, length 3, re-strobe inside gate ignored, gate_ext ignored
    cfg_int_gate = 1'b1; cfg_gate_len = 8'd3;
    @(negedge clk); strobe = 1'b1; din = '0; gate_ext = 1'b1;
    @(negedge clk); strobe = 1'b0; din = 16'h0002;
    @(negedge clk); strobe = 1'b1; din = 16'h0020;
    @(negedge clk); strobe = 1'b0; din = 16'h0200;
    @(negedge clk); din = 16'h2000;
    exp_q.push_back(16'h0222);
    @(negedge clk); din = '0; gate_ext = 1'b0;
    tick(5);
    check("R5 internal gate word consumed", exp_q.size(), 0);
    // R5: length 0 acts as 1
    cfg_gate_len = 8'd0;
    @(negedge clk); strobe = 1'b1; din = '0;
    @(negedge clk); strobe = 1'b0; din = 16'h4000;
    @(negedge clk); din = 16'h0004;
    exp_q.push_back(16'h4000);
    @(negedge clk); din = '0;
    tick(4);
    check("R5 zero length word consumed", exp_q.size(), 0);
    cfg_int_gate = 1'b0; cfg_latch_mode = 1'b0; cfg_gate_len = 8'd3;

    // R6: held words wait for buf_cmd; newer capture replaces older
    cfg_auto_store = 1'b0;
    strobe_word(16'hAAAA, 1'b0);
    strobe_word(16'h5555, 1'b0);
    tick(4);
    check("R6 nothing stored before buf_cmd", int'(empty), 1);
    exp_q.push_back(16'h5555);
    @(negedge clk); buf_cmd = 1'b1;
    @(negedge clk); buf_cmd = 1'b0;
    tick(3);
    check("R6 held word stored on buf_cmd", exp_q.size(), 0);
    @(negedge clk); buf_cmd = 1'b1;
    @(negedge clk); buf_cmd = 1'b0;
    tick(3);
    check("R6 buf_cmd without held word", int'(empty), 1);
    cfg_auto_store = 1'b1;

    // R9: read while empty ignored
    mon_en = 1'b0;
    tick(1);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    strobe_word(16'h0777, 1'b1);
    tick(2);
    check("R9 count after empty read", int'(count), 1);

    // R7: irq at count == 3 only
    cfg_irq_level = (DL+1)'(3);
    strobe_word(16'h0001, 1'b1);
    tick(2);
    check("R7 irq low at 2", int'(irq), 0);
    strobe_word(16'h0002, 1'b1);
    tick(2);
    check("R7 irq high at 3", int'(irq), 1);
    strobe_word(16'h0003, 1'b1);
    tick(2);
    check("R7 irq low at 4", int'(irq), 0);
    cfg_irq_level = '0;

    // R8: fill, one extra dropped, flag sticky
    for (int i = 4; i < DEPTH; i++) strobe_word(DW'(16'h1000 + i), 1'b1);
    tick(2);
    check("R8 full", int'(full), 1);
    check("R8 no overflow yet", int'(overflow), 0);
    strobe_word(16'hDEAD, 1'b0);
    tick(2);
    check("R8 count unchanged", int'(count), DEPTH);
    check("R8 overflow set", int'(overflow), 1);
    mon_en = 1'b1;
    tick(DEPTH + 6);
    check("R8 drained", int'(empty), 1);
    check("R8 overflow sticky", int'(overflow), 1);

    // R9: continuous write while reading
    for (int i = 0; i < 8; i++) strobe_word(DW'(16'h3300 + i * 7), 1'b1);
    tick(6);
    check("R9 streamed words consumed", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule